// File: doc/BRIEF.md
# Adaptive Data Eye Centering Controller

This block keeps the capture point of a double-data-rate parallel bus centred in the data eye. Each beat carries two symbols, the one taken on the rising edge of the forwarded clock and the one taken on the falling edge. For every symbol the receiver supplies three samples: the capture sample itself plus one taken slightly ahead of it and one slightly behind it. When the capture sample differs from one of its neighbours, a data transition lies near the capture edge. That gives an early/late vote. The votes are averaged over a sliding window, and the result drives a 5-bit tap index for a delay line on the data clock.

Captured symbols flow out on a valid/ready stream with one register stage. An upstream beat is taken only when `s_valid` and `s_ready` are both high. `s_ready` is low while the output register holds an unconsumed word, and also for a settling time after any tap change. This keeps samples taken across a delay step out of both the stream and the window, and no beat is lost or repeated. The output holds `m_valid` and `m_data` stable until `m_ready` takes the word.

A small register port selects the mode, the threshold and the tap, starts a calibration sweep, and reads status. The modes are manual, monitor-only and self-correcting. The self-correcting mode only acts after a calibration sweep has succeeded.

Top module: `eye_centering_ctrl`

## Requirements
- R1: After reset the tap is 16, the mode is manual (code 0), the threshold is 4, the sticky flag, `irq`, `m_valid` and the calibrated bit are all 0.
- R2: Every accepted beat's capture word `s_mid` appears exactly once on `m_data`, in order. `m_valid`/`m_data` hold while `m_ready` is low. `s_ready` is high only when the output register is empty or being drained, and no settling time is running.
- R3: Per accepted beat, let A be the number of bits where `s_early` differs from `s_mid`, and B the number where `s_late` differs from `s_mid`, over both halves (bits [DW-1:0] rising edge, [2DW-1:DW] falling edge). The vote is +1 if A>B, -1 if B>A, and 0 otherwise.
- R4: The filtered error is the sum of the votes of the last 8 accepted beats since the window was last cleared. It is readable as a signed 5-bit field at status bits [12:8].
- R5: A misalignment exists when the filtered sum is nonzero and its magnitude is at least max(T,1). T is the threshold in control bits [7:4]. A positive sum asks for a higher tap and a negative sum for a lower one.
- R6: Register address 1 bits [4:0] set the tap directly when the mode is manual (code 0, or code 3 treated as manual). In manual mode the tap never moves on its own.
- R7: In monitor mode (code 1) a misalignment sets the sticky flag and `irq`, clears the window, and leaves the tap unchanged.
- R8: In automatic mode (code 2), once calibrated, a misalignment moves the tap by one step in the direction of the sum and clears the window. Any tap change holds `s_ready` low for SETTLE (4) cycles.
- R9: The tap saturates at 0 and 31 and never wraps.
- R10: Writing 1 to bit 0 of address 3 starts a sweep. The sweep visits taps 0 to 31 and takes CAL_N (16) beats at each. A tap counts as clean if none of its beats shows a transition. The tap is then set to the lower middle of the first longest clean run, and the calibrated bit (status bit 17) is set. If no tap is clean, the tap goes to 16, the calibrated bit stays 0 and the flag is set. Automatic mode makes no correction while the block is uncalibrated. Status bit 18 is high during the sweep.
- R11: Status (address 2) shows the tap in bits [4:0] and the sticky flag in bit 16. Writing 1 to bit 16 clears the flag. The flag otherwise stays set, and `irq` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat accepted when high with s_valid |
| s_early | input | 2*DW | Samples taken ahead of the capture edge |
| s_mid | input | 2*DW | Samples at the capture edge |
| s_late | input | 2*DW | Samples taken after the capture edge |
| m_valid | output | 1 | Captured word valid |
| m_ready | input | 1 | Downstream takes the captured word |
| m_data | output | 2*DW | Captured word |
| tap_o | output | 5 | Delay line tap index |
| irq | output | 1 | Sticky misalignment / calibration failure flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions check on every cycle that the filtered sum stays within the window bounds, and that outside calibration and manual writes the tap moves by at most one step. They also check that the tap cannot wrap at 31, that it holds in monitor mode and while uncalibrated, that a tap change closes `s_ready`, that the output stream holds under back-pressure, and how the sticky flag sets and clears. Only the bench scenarios can show the rest. These cover the exact windowed sum under mixed vote patterns, the threshold crossing point, the length of the settling gap, the centre chosen by a sweep and the failed-sweep outcome. They also cover convergence onto a moved eye and lossless ordering of the data stream under random back-pressure.

// File: rtl/eyec_pkg.sv
package eyec_pkg;
  typedef enum logic [1:0] {
    MODE_MANUAL  = 2'd0,
    MODE_MONITOR = 2'd1,
    MODE_AUTO    = 2'd2,
    MODE_RSVD    = 2'd3
  } eye_mode_e;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_TAP    = 1;
  localparam int unsigned REG_STATUS = 2;
  localparam int unsigned REG_CAL    = 3;
endpackage

// File: rtl/eyec_phase_det.sv
module eyec_phase_det #(
  parameter int NB = 8
) (
  input  logic [NB-1:0]      early,
  input  logic [NB-1:0]      mid,
  input  logic [NB-1:0]      late,
  output logic signed [1:0]  vote,
  output logic               clean
);
  function automatic int unsigned ones(input logic [NB-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < NB; i++) n += int'(v[i]);
    return n;
  endfunction

  int unsigned lead_hits, lag_hits;

  always_comb begin
    lead_hits = ones(early ^ mid);
    lag_hits  = ones(mid ^ late);
    clean     = (lead_hits == 0) && (lag_hits == 0);
    if (lead_hits > lag_hits)      vote = 2'sb01;
    else if (lag_hits > lead_hits) vote = 2'sb11;
    else                           vote = 2'sb00;
  end
endmodule

// File: rtl/eyec_avg_filter.sv
module eyec_avg_filter #(
  parameter int WIN = 8,
  parameter int SW  = $clog2(WIN) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [1:0]    vote,
  input  logic                 clr,
  output logic signed [SW-1:0] sum
);
  localparam logic signed [SW-1:0] SMAX = SW'(WIN);

  logic signed [1:0] hist [WIN];
  logic [SW-1:0] add_x, sub_x;

  always_comb begin
    add_x = {{(SW-2){vote[1]}}, vote};
    sub_x = {{(SW-2){hist[WIN-1][1]}}, hist[WIN-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) hist[i] <= '0;
      sum <= '0;
    end else if (clr) begin
      for (int i = 0; i < WIN; i++) hist[i] <= '0;
      sum <= '0;
    end else if (push) begin
      hist[0] <= vote;
      for (int i = 1; i < WIN; i++) hist[i] <= hist[i-1];
      sum <= sum + $signed(add_x) - $signed(sub_x);
    end
  end

  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sum <= SMAX) && (sum >= -SMAX)); // R4

  AST_SUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |=> ((sum - $past(sum)) <= 2) && ((sum - $past(sum)) >= -2)); // R4
endmodule

// File: rtl/eyec_regs.sv
module eyec_regs
  import eyec_pkg::*;
#(
  parameter int TW  = 5,
  parameter int SW  = 5,
  parameter int THW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [TW-1:0]        tap,
  input  logic signed [SW-1:0] sum,
  input  logic                 cal_done,
  input  logic                 cal_busy,
  input  logic                 flag_set,
  output eye_mode_e            mode,
  output logic [THW-1:0]       thr,
  output logic                 man_we,
  output logic [TW-1:0]        man_tap,
  output logic                 cal_start,
  output logic                 flag
);
  logic flag_clr;

  assign man_we    = we && (addr == 2'(REG_TAP));
  assign man_tap   = wdata[TW-1:0];
  assign cal_start = we && (addr == 2'(REG_CAL)) && wdata[0];
  assign flag_clr  = we && (addr == 2'(REG_STATUS)) && wdata[16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_MANUAL;
      thr  <= THW'(4);
      flag <= 1'b0;
    end else begin
      if (we && (addr == 2'(REG_CTRL))) begin
        mode <= eye_mode_e'(wdata[1:0]);
        thr  <= wdata[4 +: THW];
      end
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'(REG_CTRL): begin
        rdata[1:0]      = mode;
        rdata[4 +: THW] = thr;
      end
      2'(REG_TAP):    rdata[TW-1:0] = tap;
      2'(REG_STATUS): begin
        rdata[TW-1:0]  = tap;
        rdata[8 +: SW] = sum;
        rdata[16]      = flag;
        rdata[17]      = cal_done;
        rdata[18]      = cal_busy;
      end
      default:        rdata[0] = cal_busy;
    endcase
  end

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !flag); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R11
endmodule

// File: rtl/eyec_tap_ctrl.sv
module eyec_tap_ctrl
  import eyec_pkg::*;
#(
  parameter int TAPS   = 32,
  parameter int TW     = $clog2(TAPS),
  parameter int SW     = 5,
  parameter int THW    = 4,
  parameter int SETTLE = 4,
  parameter int CAL_N  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  eye_mode_e            mode,
  input  logic [THW-1:0]       thr,
  input  logic signed [SW-1:0] sum,
  input  logic                 acc,
  input  logic                 clean,
  input  logic                 man_we,
  input  logic [TW-1:0]        man_tap,
  input  logic                 cal_start,
  output logic [TW-1:0]        tap,
  output logic                 settling,
  output logic                 clr_hist,
  output logic                 flag_set,
  output logic                 cal_done,
  output logic                 cal_busy
);
  localparam int SCW = $clog2(SETTLE + 1);
  localparam int CCW = $clog2(CAL_N + 1);
  localparam logic [TW-1:0] TAP_MAX = TW'(TAPS - 1);
  localparam logic [TW-1:0] TAP_MID = TW'(TAPS / 2);

  logic [SCW-1:0]  settle_cnt;
  logic [CCW-1:0]  cal_cnt;
  logic            cal_dirty;
  logic [TAPS-1:0] clean_map, next_map;
  logic [THW-1:0]  thr_eff;
  logic [SW-1:0]   mag;
  logic            over, want_up, decide, auto_go, mon_go, man_go;
  logic            cal_last, cal_step, cal_end, tap_chg;
  logic            found;
  logic [TW-1:0]   center;
  int              rl, rs, bl, bs;

  // error magnitude against the effective threshold
  always_comb begin
    thr_eff = (thr == '0) ? THW'(1) : thr;
    mag     = sum[SW-1] ? SW'(-sum) : SW'(sum);
    over    = (sum != '0) && (mag >= {{(SW-THW){1'b0}}, thr_eff});
    want_up = !sum[SW-1];
  end

  assign settling = (settle_cnt != '0);
  assign decide   = !cal_busy && !settling && over;
  assign auto_go  = decide && (mode == MODE_AUTO) && cal_done;
  assign mon_go   = decide && (mode == MODE_MONITOR);
  assign man_go   = man_we && !cal_busy && !cal_start &&
                    ((mode == MODE_MANUAL) || (mode == MODE_RSVD));
  assign cal_last = cal_busy && acc && (cal_cnt == CCW'(CAL_N - 1));
  assign cal_step = cal_last && (tap != TAP_MAX);
  assign cal_end  = cal_last && (tap == TAP_MAX);
  assign tap_chg  = auto_go || man_go || cal_start || cal_step || cal_end;
  assign clr_hist = tap_chg || mon_go;
  assign flag_set = mon_go || (cal_end && !found);

  // clean map including the result for the tap being finished now
  always_comb begin
    next_map      = clean_map;
    next_map[tap] = !cal_dirty && clean;
  end

  // first longest run of clean taps
  always_comb begin
    rl = 0; rs = 0; bl = 0; bs = 0;
    for (int i = 0; i < TAPS; i++) begin
      if (next_map[i]) begin
        if (rl == 0) rs = i;
        rl = rl + 1;
        if (rl > bl) begin
          bl = rl;
          bs = rs;
        end
      end else begin
        rl = 0;
      end
    end
    found  = (bl > 0);
    center = found ? TW'(bs + (bl - 1) / 2) : TAP_MID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap       <= TAP_MID;
      cal_busy  <= 1'b0;
      cal_done  <= 1'b0;
      cal_cnt   <= '0;
      cal_dirty <= 1'b0;
      clean_map <= '0;
    end else if (cal_start) begin
      tap       <= '0;
      cal_busy  <= 1'b1;
      cal_done  <= 1'b0;
      cal_cnt   <= '0;
      cal_dirty <= 1'b0;
      clean_map <= '0;
    end else if (cal_busy) begin
      if (acc) begin
        if (cal_last) begin
          clean_map <= next_map;
          cal_cnt   <= '0;
          cal_dirty <= 1'b0;
          if (cal_end) begin
            cal_busy <= 1'b0;
            cal_done <= found;
            tap      <= center;
          end else begin
            tap <= tap + TW'(1);
          end
        end else begin
          cal_cnt   <= cal_cnt + CCW'(1);
          cal_dirty <= cal_dirty || !clean;
        end
      end
    end else if (man_go) begin
      tap <= man_tap;
    end else if (auto_go) begin
      if (want_up && (tap != TAP_MAX))   tap <= tap + TW'(1);
      else if (!want_up && (tap != '0))  tap <= tap - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          settle_cnt <= '0;
    else if (tap_chg)    settle_cnt <= SCW'(SETTLE);
    else if (settling)   settle_cnt <= settle_cnt - SCW'(1);
  end

  AST_TAP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_go && !cal_busy && !cal_start) |=>
      (tap == $past(tap)) || (tap == $past(tap) + 1) || (tap == $past(tap) - 1)); // R8

  AST_TAP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == TAP_MAX && !man_go && !cal_start && !cal_busy) |=> (tap >= TAP_MAX - TW'(1))); // R9

  AST_MONITOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MONITOR && !cal_busy && !cal_start) |=> $stable(tap)); // R7

  AST_UNCAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_done && !cal_busy && !cal_start && !man_go) |=> $stable(tap)); // R10
endmodule

// File: rtl/eye_centering_ctrl.sv
module eye_centering_ctrl
  import eyec_pkg::*;
#(
  parameter int DW     = 8,
  parameter int TAPS   = 32,
  parameter int WIN    = 8,
  parameter int THW    = 4,
  parameter int SETTLE = 4,
  parameter int CAL_N  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [2*DW-1:0]   s_early,
  input  logic [2*DW-1:0]   s_mid,
  input  logic [2*DW-1:0]   s_late,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [2*DW-1:0]   m_data,
  output logic [$clog2(TAPS)-1:0] tap_o,
  output logic              irq,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  localparam int NB = 2 * DW;
  localparam int TW = $clog2(TAPS);
  localparam int SW = $clog2(WIN) + 2;

  logic signed [1:0]    vote;
  logic                 clean, acc, settling, clr_hist, flag_set;
  logic                 cal_done, cal_busy, man_we, cal_start;
  logic signed [SW-1:0] sum;
  logic [THW-1:0]       thr;
  logic [TW-1:0]        man_tap;
  eye_mode_e            mode;

  assign s_ready = (!m_valid || m_ready) && !settling;
  assign acc     = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (acc) begin
      m_valid <= 1'b1;
      m_data  <= s_mid;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  eyec_phase_det #(.NB(NB)) u_pd (
    .early(s_early), .mid(s_mid), .late(s_late), .vote(vote), .clean(clean)
  );

  eyec_avg_filter #(.WIN(WIN), .SW(SW)) u_flt (
    .clk(clk), .rst_n(rst_n), .push(acc), .vote(vote), .clr(clr_hist), .sum(sum)
  );

  eyec_tap_ctrl #(
    .TAPS(TAPS), .TW(TW), .SW(SW), .THW(THW), .SETTLE(SETTLE), .CAL_N(CAL_N)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .thr(thr), .sum(sum), .acc(acc),
    .clean(clean), .man_we(man_we), .man_tap(man_tap), .cal_start(cal_start),
    .tap(tap_o), .settling(settling), .clr_hist(clr_hist), .flag_set(flag_set),
    .cal_done(cal_done), .cal_busy(cal_busy)
  );

  eyec_regs #(.TW(TW), .SW(SW), .THW(THW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .tap(tap_o), .sum(sum), .cal_done(cal_done),
    .cal_busy(cal_busy), .flag_set(flag_set), .mode(mode), .thr(thr),
    .man_we(man_we), .man_tap(man_tap), .cal_start(cal_start), .flag(irq)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R2

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_o != $past(tap_o)) |-> !s_ready); // R8
endmodule

// File: tb/tb_eye_centering_ctrl.sv
module tb_eye_centering_ctrl;
  localparam int DW = 4, NB = 8, TAPS = 32, WIN = 8, SETTLE = 4, CAL_N = 16;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, m_valid, m_ready = 1, irq;
  logic [NB-1:0] s_early = 0, s_mid = 0, s_late = 0, m_data;
  logic [4:0] tap_o;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;

  always #10 clk = ~clk;

  eye_centering_ctrl #(.DW(DW), .TAPS(TAPS), .WIN(WIN), .THW(4), .SETTLE(SETTLE), .CAL_N(CAL_N)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_early(s_early),
    .s_mid(s_mid), .s_late(s_late), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .tap_o(tap_o), .irq(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  bit drv_en = 0, have_beat = 0, rdy_rand = 0, sready_seen;
  int pat = 3, eye_lo = 0, eye_hi = 31, acc_cnt = 0;
  logic [NB-1:0] beat_mid;
  logic [31:0] last_rdata;
  logic [4:0] tap_seen;
  logic [NB-1:0] exp_mem [0:8191];
  int wp = 0, rp = 0;
  int vh [WIN];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int vote_of(input logic [NB-1:0] e, m, l);
    int a = 0, b = 0;
    for (int i = 0; i < NB; i++) begin
      a += int'(e[i] ^ m[i]);
      b += int'(m[i] ^ l[i]);
    end
    return (a > b) ? 1 : ((b > a) ? -1 : 0);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < WIN; i++) vh[i] = 0;
  endtask

  function automatic int model_sum();
    int s = 0;
    for (int i = 0; i < WIN; i++) s += vh[i];
    return s;
  endfunction

  task automatic tick(input bit we, input logic [1:0] addr, input logic [31:0] wd);
    int p;
    logic [NB-1:0] e, l;
    @(negedge clk);
    cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    if (drv_en) begin
      if (!have_beat) begin beat_mid = NB'($urandom); have_beat = 1; end
      p = (pat == 7) ? 1 + int'($urandom % 6) : pat;
      e = beat_mid; l = beat_mid;
      case (p)
        0: if (int'(tap_o) < eye_lo) e = ~beat_mid;
           else if (int'(tap_o) > eye_hi) l = ~beat_mid;
        1: e = ~beat_mid;
        2: l = ~beat_mid;
        4: begin e = beat_mid ^ 8'h01; l = beat_mid ^ 8'hE0; end
        5: begin e = beat_mid ^ 8'h30; l = beat_mid ^ 8'h01; end
        6: begin e = beat_mid ^ 8'h01; l = beat_mid ^ 8'h02; end
        default: ;
      endcase
      s_mid = beat_mid; s_early = e; s_late = l; s_valid = 1;
    end else begin
      s_valid = 0;
    end
    m_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
    #9;
    last_rdata = cfg_rdata; tap_seen = tap_o; sready_seen = s_ready;
    if (s_valid && s_ready) begin
      exp_mem[wp % 8192] = s_mid; wp++;
      for (int i = WIN - 1; i > 0; i--) vh[i] = vh[i-1];
      vh[0] = vote_of(s_early, s_mid, s_late);
      have_beat = 0; acc_cnt++;
    end
    if (m_valid && m_ready) begin
      chk(m_data == exp_mem[rp % 8192], "R2 stream order", int'(m_data), int'(exp_mem[rp % 8192]));
      rp++;
    end
  endtask

  task automatic feed(input int n);
    int target = acc_cnt + n;
    drv_en = 1;
    while (acc_cnt < target) tick(0, 2, 0);
    drv_en = 0;
  endtask

  task automatic wait_cal();
    bit done = 0;
    for (int i = 0; i < 4000 && !done; i++) begin
      tick(0, 2, 0);
      if (!last_rdata[18]) done = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev, low_run, mstate;
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) tick(0, 0, 0);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    tick(0, 2, 0);
    chk(tap_o == 5'd16, "R1 tap", int'(tap_o), 16);
    chk(!irq && !m_valid, "R1 irq/m_valid", int'({irq, m_valid}), 0);
    chk(last_rdata[17:16] == 2'b00, "R1 flag/cal", int'(last_rdata[17:16]), 0);
    tick(0, 0, 0);
    chk(last_rdata[7:0] == 8'h40, "R1 ctrl", int'(last_rdata[7:0]), 8'h40);

    // R6 manual tap write, no self motion
    tick(1, 1, 7); model_clear();
    tick(0, 0, 0);
    chk(tap_o == 5'd7, "R6 manual write", int'(tap_o), 7);
    tick(1, 0, 32'h10);
    pat = 1; drv_en = 1; repeat (30) tick(0, 0, 0); drv_en = 0;
    tick(0, 0, 0);
    chk(tap_o == 5'd7 && !irq, "R6 manual hold", int'(tap_o), 7);

    // R3 R4 windowed sum under mixed votes, random back-pressure
    tick(1, 1, 10); model_clear();
    tick(1, 0, 32'hF1);
    rdy_rand = 1; pat = 7;
    for (int r = 0; r < 3; r++) begin
      drv_en = 1; repeat (30 + r * 7) tick(0, 2, 0);
      drv_en = 0; repeat (4) tick(0, 2, 0);
      chk($signed(last_rdata[12:8]) == model_sum(), "R3 R4 filtered sum",
          int'($signed(last_rdata[12:8])), model_sum());
      chk(tap_o == 5'd10, "R7 monitor tap", int'(tap_o), 10);
    end
    rdy_rand = 0;

    // R5 R7 R11 threshold crossing in monitor mode
    tick(1, 0, 32'h30); tick(1, 1, 12); model_clear();
    tick(1, 2, 32'h1_0000);
    tick(1, 0, 32'h31);
    pat = 1; feed(2); repeat (3) tick(0, 2, 0);
    chk(!last_rdata[16], "R5 below threshold", int'(last_rdata[16]), 0);
    feed(1); repeat (3) tick(0, 2, 0);
    chk(last_rdata[16] && irq, "R5 R7 flag at threshold", int'(last_rdata[16]), 1);
    chk(tap_o == 5'd12, "R7 tap unchanged", int'(tap_o), 12);
    chk(last_rdata[12:8] == 5'd0, "R7 window cleared", int'(last_rdata[12:8]), 0);
    repeat (5) tick(0, 2, 0);
    chk(irq == 1'b1, "R11 sticky", int'(irq), 1);
    tick(1, 2, 32'h1_0000); tick(0, 2, 0);
    chk(!last_rdata[16] && !irq, "R11 write-one clear", int'(last_rdata[16]), 0);
    tick(1, 0, 32'h21);
    pat = 2; feed(1); repeat (3) tick(0, 2, 0);
    chk(!irq, "R5 negative below", int'(irq), 0);
    feed(1); repeat (3) tick(0, 2, 0);
    chk(irq == 1'b1, "R5 negative at threshold", int'(irq), 1);
    tick(1, 2, 32'h1_0000);
    tick(1, 0, 32'h01);
    pat = 4; feed(1); repeat (3) tick(0, 2, 0);
    chk(irq == 1'b1, "R5 zero threshold acts at one", int'(irq), 1);
    tick(1, 2, 32'h1_0000);

    // R10 auto mode idle while uncalibrated
    tick(1, 0, 32'h12);
    pat = 1; feed(10); repeat (3) tick(0, 2, 0);
    chk(tap_o == 5'd12, "R10 auto needs calibration", int'(tap_o), 12);

    // R10 failed sweep
    pat = 0; eye_lo = 99; eye_hi = -1;
    tick(1, 3, 1); drv_en = 1; wait_cal(); drv_en = 0;
    tick(0, 2, 0);
    chk(!last_rdata[17] && last_rdata[16], "R10 fail flags", int'(last_rdata[17:16]), 1);
    chk(tap_o == 5'd16, "R10 fail tap", int'(tap_o), 16);
    tick(1, 2, 32'h1_0000);

    // R10 all clean -> 15, band 9..19 -> 14
    eye_lo = 0; eye_hi = 31;
    tick(1, 3, 1); drv_en = 1; wait_cal(); drv_en = 0;
    tick(0, 2, 0);
    chk(tap_o == 5'd15 && last_rdata[17], "R10 full eye centre", int'(tap_o), 15);
    eye_lo = 9; eye_hi = 19;
    tick(1, 3, 1); drv_en = 1; wait_cal();
    repeat (20) tick(0, 2, 0);
    drv_en = 0; tick(0, 2, 0);
    chk(tap_o == 5'd14 && last_rdata[17], "R10 band centre", int'(tap_o), 14);

    // R8 tracking with settle gap
    tick(1, 0, 32'h22);
    eye_lo = 20; eye_hi = 24; pat = 0; drv_en = 1;
    prev = int'(tap_o); mstate = 0; low_run = 0;
    repeat (400) begin
      tick(0, 0, 0);
      if (int'(tap_seen) != prev) begin
        chk(int'(tap_seen) - prev == 1, "R8 single step", int'(tap_seen) - prev, 1);
        if (mstate == 0) begin mstate = 1; low_run = 0; end
        prev = int'(tap_seen);
      end
      if (mstate == 1) begin
        if (!sready_seen) low_run++;
        else begin
          mstate = 2;
          chk(low_run == SETTLE, "R8 settle gap", low_run, SETTLE);
        end
      end
    end
    chk(tap_o == 5'd20, "R8 converged", int'(tap_o), 20);

    // R9 saturation
    pat = 1; repeat (400) tick(0, 0, 0);
    chk(tap_o == 5'd31, "R9 top", int'(tap_o), 31);
    repeat (60) tick(0, 0, 0);
    chk(tap_o == 5'd31, "R9 top hold", int'(tap_o), 31);
    pat = 2; repeat (600) tick(0, 0, 0);
    chk(tap_o == 5'd0, "R9 bottom", int'(tap_o), 0);
    drv_en = 0; repeat (5) tick(0, 0, 0);
    chk(rp == wp, "R2 all delivered", rp, wp);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule